// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

This block models a pipelined synchronous static RAM. The word is split into byte lanes, four lanes of nine bits by default, and the depth is set by a parameter. Every control, address and data input is sampled on the rising clock edge. An access begins when one of two active-low address strobes is asserted. The processor strobe is honoured only while the pipelining select is active. The controller strobe is always honoured. Either strobe loads a base address and latches the combined chip-select state.

After the strobe cycle, an active-low advance input steps a 2-bit burst counter. The counter selects the next word inside an aligned four-word block, in linear or interleaved order. Writes happen on the same edge that samples them. A write can cover any chosen set of byte lanes, or every lane through a global write. Read data passes through a two-register pipeline, so a four-beat burst gives a 3-1-1-1 pattern. An asynchronous output enable gates the output-valid flag, which stands in for the tri-state data drive.

Top module: `sram_pipe_burst`

## Requirements
- R1: While `rst` is high at a rising edge, the read pipeline clears. `rdata_valid` is low after that edge and stays low until a read has passed through the pipeline.
- R2: A read sampled at edge k shows its word on `rdata` with `rdata_valid` high after edge k+1, provided `out_en_n` is low. Each further advance cycle delivers one more word.
- R3: A low `strobe_cpu_n` with `sel_pipe_n` high and `strobe_ctl_n` high loads nothing. That cycle behaves as a burst continuation of the current access.
- R4: On a cycle with no accepted strobe, a low `advance_n` steps the burst counter by one, modulo 4. A high `advance_n` leaves the counter unchanged, so the same word is accessed again.
- R5: With `burst_linear` = 1, the low two address bits are (start + count) mod 4. The upper address bits stay fixed.
- R6: With `burst_linear` = 0, the low two address bits are start XOR count. The upper address bits stay fixed.
- R7: With `lane_gate_n` low and `wr_all_n` high, lane i (bits 9i+8 down to 9i) is written exactly when `lane_wr_n[i]` is low. All other lanes keep their contents.
- R8: With `wr_all_n` low, all lanes are written, whatever `lane_gate_n` and `lane_wr_n` hold.
- R9: A cycle started by the processor strobe is always a read, whatever the write inputs hold. A cycle started by the controller strobe writes on that same edge when any lane is requested. Continuation cycles write at the current burst address.
- R10: `rdata_valid` falls as soon as `out_en_n` goes high and rises again as soon as it goes low, with no clock edge in between.
- R11: A strobe cycle that samples `sel_pipe_n` high, `sel_hi` low or `sel_lo_n` high deselects the device. It neither reads nor writes from that edge until the next strobe, and `rdata_valid` is low after the following edge.
- R12: A write cycle produces no output word. `rdata_valid` is low after the edge that follows a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_in | input | ADDR_W | Word address loaded on a strobe |
| strobe_cpu_n | input | 1 | Processor address strobe, active low |
| strobe_ctl_n | input | 1 | Controller address strobe, active low |
| advance_n | input | 1 | Burst advance, active low |
| sel_pipe_n | input | 1 | Pipelining select, active low |
| sel_hi | input | 1 | Depth-expansion select, active high |
| sel_lo_n | input | 1 | Depth-expansion select, active low |
| wr_all_n | input | 1 | Global write of all lanes, active low |
| lane_gate_n | input | 1 | Enables the per-lane write strobes, active low |
| lane_wr_n | input | LANES | Per-lane write strobes, active low |
| burst_linear | input | 1 | 1 selects linear order, 0 selects interleaved order |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| wdata | input | LANES*LANE_W | Write data |
| rdata | output | LANES*LANE_W | Registered read data |
| rdata_valid | output | 1 | High when the data output would be driven |

## Verification
Bursts are run from every starting offset in both orders, using each strobe in turn. A wrong wrap point or a mixed-up linear/interleaved rule therefore shows up as a wrong word. Hold cycles are interleaved with advance cycles, which separates counter stepping from repeated access. Lane-masked writes use non-adjacent lane patterns. Global writes are issued with contradictory lane strobes. A processor-strobe cycle is issued with writes requested, and read back afterwards to prove nothing was stored. Deselects use each of the three selects in turn. The output enable is toggled between clock edges to expose any registered gating.

// File: rtl/sram_burst_pkg.sv
package sram_burst_pkg;
  localparam int BURST_W = 2;

  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_e;

  // Offset of a beat inside the aligned four-word block.
  function automatic logic [BURST_W-1:0] burst_offset(
    input logic [BURST_W-1:0] start,
    input logic [BURST_W-1:0] step,
    input logic               linear
  );
    return linear ? (start + step) : (start ^ step);
  endfunction
endpackage

// File: rtl/sram_burst_order.sv
module sram_burst_order
  import sram_burst_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0]  base,
  input  logic [BURST_W-1:0] count,
  input  logic               linear,
  output logic [ADDR_W-1:0]  word_addr
);
  // Upper bits pass straight through; only the low bits follow the order.
  always_comb begin
    word_addr = base;
    word_addr[BURST_W-1:0] = burst_offset(base[BURST_W-1:0], count, linear);
  end
endmodule

// File: rtl/sram_burst_seq.sv
module sram_burst_seq
  import sram_burst_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  addr_in,
  input  logic               strobe_cpu_n,
  input  logic               strobe_ctl_n,
  input  logic               advance_n,
  input  logic               sel_pipe_n,
  input  logic               sel_hi,
  input  logic               sel_lo_n,
  input  logic               wr_all_n,
  input  logic               lane_gate_n,
  input  logic [LANES-1:0]   lane_wr_n,
  input  logic               burst_linear,
  output acc_e               acc_kind,
  output logic [ADDR_W-1:0]  acc_addr,
  output logic [LANES-1:0]   acc_lanes,
  output logic [ADDR_W-1:0]  base_o,
  output logic [BURST_W-1:0] count_o
);
  logic [ADDR_W-1:0]  base_q, base_n;
  logic [BURST_W-1:0] cnt_q, cnt_n;
  logic               en_q, en_n;
  logic               ctl_start, cpu_start, any_start, selected;
  logic [LANES-1:0]   lanes_req;

  assign ctl_start = ~strobe_ctl_n;
  assign cpu_start = ~strobe_cpu_n & ~sel_pipe_n & strobe_ctl_n;
  assign any_start = ctl_start | cpu_start;
  assign selected  = ~sel_pipe_n & sel_hi & ~sel_lo_n;

  always_comb begin
    if (any_start) begin
      base_n = addr_in;
      cnt_n  = '0;
      en_n   = selected;
    end else begin
      base_n = base_q;
      cnt_n  = advance_n ? cnt_q : cnt_q + 1'b1;
      en_n   = en_q;
    end
  end

  always_comb begin
    if (!wr_all_n)         lanes_req = '1;
    else if (!lane_gate_n) lanes_req = ~lane_wr_n;
    else                   lanes_req = '0;
  end

  sram_burst_order #(.ADDR_W(ADDR_W)) order_i (
    .base      (base_n),
    .count     (cnt_n),
    .linear    (burst_linear),
    .word_addr (acc_addr)
  );

  always_comb begin
    acc_kind  = ACC_NONE;
    acc_lanes = '0;
    if (en_n) begin
      if (!cpu_start && (|lanes_req)) begin
        acc_kind  = ACC_WRITE;
        acc_lanes = lanes_req;
      end else begin
        acc_kind = ACC_READ;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      cnt_q  <= '0;
      en_q   <= 1'b0;
    end else begin
      base_q <= base_n;
      cnt_q  <= cnt_n;
      en_q   <= en_n;
    end
  end

  assign base_o  = base_q;
  assign count_o = cnt_q;
endmodule

// File: rtl/sram_lane_ram.sv
module sram_lane_ram #(
  parameter int ADDR_W = 8,
  parameter int LANE_W = 9
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANE_W-1:0] wd,
  output logic [LANE_W-1:0] q
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [LANE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wd;
    q <= mem[addr];
  end
endmodule

// File: rtl/sram_pipe_burst.sv
module sram_pipe_burst
  import sram_burst_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [ADDR_W-1:0]         addr_in,
  input  logic                      strobe_cpu_n,
  input  logic                      strobe_ctl_n,
  input  logic                      advance_n,
  input  logic                      sel_pipe_n,
  input  logic                      sel_hi,
  input  logic                      sel_lo_n,
  input  logic                      wr_all_n,
  input  logic                      lane_gate_n,
  input  logic [LANES-1:0]          lane_wr_n,
  input  logic                      burst_linear,
  input  logic                      out_en_n,
  input  logic [LANES*LANE_W-1:0]   wdata,
  output logic [LANES*LANE_W-1:0]   rdata,
  output logic                      rdata_valid
);
  localparam int DATA_W = LANES * LANE_W;

  acc_e               acc_kind;
  logic [ADDR_W-1:0]  acc_addr;
  logic [LANES-1:0]   acc_lanes;
  logic [ADDR_W-1:0]  burst_base;
  logic [BURST_W-1:0] burst_cnt;
  logic [DATA_W-1:0]  ram_q;
  logic               rd_stage_q, out_stage_q;
  logic [DATA_W-1:0]  rdata_q;

  sram_burst_seq #(.ADDR_W(ADDR_W), .LANES(LANES)) seq_i (
    .clk          (clk),
    .rst          (rst),
    .addr_in      (addr_in),
    .strobe_cpu_n (strobe_cpu_n),
    .strobe_ctl_n (strobe_ctl_n),
    .advance_n    (advance_n),
    .sel_pipe_n   (sel_pipe_n),
    .sel_hi       (sel_hi),
    .sel_lo_n     (sel_lo_n),
    .wr_all_n     (wr_all_n),
    .lane_gate_n  (lane_gate_n),
    .lane_wr_n    (lane_wr_n),
    .burst_linear (burst_linear),
    .acc_kind     (acc_kind),
    .acc_addr     (acc_addr),
    .acc_lanes    (acc_lanes),
    .base_o       (burst_base),
    .count_o      (burst_cnt)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sram_lane_ram #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) ram_i (
      .clk  (clk),
      .we   (acc_kind == ACC_WRITE && acc_lanes[g]),
      .addr (acc_addr),
      .wd   (wdata[g*LANE_W +: LANE_W]),
      .q    (ram_q[g*LANE_W +: LANE_W])
    );
  end

  // Stage 1: array read registered; stage 2: output register.
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_stage_q  <= 1'b0;
      out_stage_q <= 1'b0;
    end else begin
      rd_stage_q  <= (acc_kind == ACC_READ);
      out_stage_q <= rd_stage_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rd_stage_q) rdata_q <= ram_q;
  end

  assign rdata       = rdata_q;
  assign rdata_valid = out_stage_q & ~out_en_n;
endmodule

// File: rtl/sram_pipe_burst_chk.sv
module sram_pipe_burst_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr_in,
  input logic              strobe_cpu_n,
  input logic              strobe_ctl_n,
  input logic              advance_n,
  input logic              sel_pipe_n,
  input logic              sel_hi,
  input logic              sel_lo_n,
  input logic              wr_all_n,
  input logic              out_en_n,
  input logic              rdata_valid,
  input logic [ADDR_W-1:0] burst_base,
  input logic [1:0]        burst_cnt
);
  logic no_start;
  assign no_start = strobe_ctl_n & (strobe_cpu_n | sel_pipe_n);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> !rdata_valid);

  assert_ctl_load_R2: assert property (@(posedge clk) disable iff (rst)
    !strobe_ctl_n |=> (burst_cnt == 2'd0) && (burst_base == $past(addr_in)));

  assert_cpu_ignored_R3: assert property (@(posedge clk) disable iff (rst)
    (!strobe_cpu_n && sel_pipe_n && strobe_ctl_n) |=> burst_base == $past(burst_base));

  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (no_start && advance_n) |=> $stable(burst_cnt));

  assert_step_R4: assert property (@(posedge clk) disable iff (rst)
    (no_start && !advance_n) |=> burst_cnt == $past(burst_cnt) + 2'd1);

  assert_oe_gate_R10: assert property (@(posedge clk) disable iff (rst)
    out_en_n |-> !rdata_valid);

  assert_deselect_R11: assert property (@(posedge clk) disable iff (rst)
    (!strobe_ctl_n && (sel_pipe_n || !sel_hi || sel_lo_n)) |=> ##1 !rdata_valid);

  assert_write_quiet_R12: assert property (@(posedge clk) disable iff (rst)
    (!strobe_ctl_n && !sel_pipe_n && sel_hi && !sel_lo_n && !wr_all_n) |=> ##1 !rdata_valid);
endmodule

bind sram_pipe_burst sram_pipe_burst_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .addr_in      (addr_in),
  .strobe_cpu_n (strobe_cpu_n),
  .strobe_ctl_n (strobe_ctl_n),
  .advance_n    (advance_n),
  .sel_pipe_n   (sel_pipe_n),
  .sel_hi       (sel_hi),
  .sel_lo_n     (sel_lo_n),
  .wr_all_n     (wr_all_n),
  .out_en_n     (out_en_n),
  .rdata_valid  (rdata_valid),
  .burst_base   (burst_base),
  .burst_cnt    (burst_cnt)
);

// File: tb/sram_pipe_burst_tb.sv
module sram_pipe_burst_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int LN = 4;
  localparam int LW = 9;
  localparam int DW = LN * LW;
  localparam int WORDS = 1 << AW;

  logic clk = 1'b0;
  logic rst;
  logic [AW-1:0] addr_in;
  logic strobe_cpu_n, strobe_ctl_n, advance_n;
  logic sel_pipe_n, sel_hi, sel_lo_n;
  logic wr_all_n, lane_gate_n;
  logic [LN-1:0] lane_wr_n;
  logic burst_linear, out_en_n;
  logic [DW-1:0] wdata, rdata;
  logic rdata_valid;

  int checks = 0;
  int fails = 0;
  string phase = "R1";

  logic [DW-1:0] ref_mem [WORDS];
  int  m_base = 0;
  int  m_cnt = 0;
  bit  m_en = 0;
  bit  mid_v = 0, out_v = 0;
  logic [DW-1:0] mid_d = '0, out_d = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_pipe_burst dut_i (
    .clk(clk), .rst(rst), .addr_in(addr_in),
    .strobe_cpu_n(strobe_cpu_n), .strobe_ctl_n(strobe_ctl_n), .advance_n(advance_n),
    .sel_pipe_n(sel_pipe_n), .sel_hi(sel_hi), .sel_lo_n(sel_lo_n),
    .wr_all_n(wr_all_n), .lane_gate_n(lane_gate_n), .lane_wr_n(lane_wr_n),
    .burst_linear(burst_linear), .out_en_n(out_en_n),
    .wdata(wdata), .rdata(rdata), .rdata_valid(rdata_valid)
  );

  // Behavioural reference, updated at each rising edge from the sampled inputs.
  always @(posedge clk) begin
    if (rst) begin
      m_base = 0; m_cnt = 0; m_en = 0; mid_v = 0; out_v = 0;
    end else begin
      bit ctl, cpu, wr;
      int lo, a;
      logic [LN-1:0] lanes;
      out_v = mid_v;
      out_d = mid_d;
      ctl = !strobe_ctl_n;
      cpu = !strobe_cpu_n && !sel_pipe_n && strobe_ctl_n;
      if (ctl || cpu) begin
        m_base = int'(addr_in);
        m_cnt = 0;
        m_en = !sel_pipe_n && sel_hi && !sel_lo_n;
      end else if (!advance_n) begin
        m_cnt = (m_cnt + 1) % 4;
      end
      lo = burst_linear ? ((m_base % 4) + m_cnt) % 4 : ((m_base % 4) ^ m_cnt);
      a = (m_base / 4) * 4 + lo;
      lanes = !wr_all_n ? '1 : (!lane_gate_n ? ~lane_wr_n : '0);
      wr = m_en && !cpu && (lanes != 0);
      mid_v = 0;
      if (wr) begin
        for (int l = 0; l < LN; l++)
          if (lanes[l]) ref_mem[a][l*LW +: LW] = wdata[l*LW +: LW];
      end else if (m_en) begin
        mid_v = 1;
        mid_d = ref_mem[a];
      end
    end
  end

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic compare();
    bit ev;
    ev = out_v && !out_en_n;
    check({phase, " valid"}, DW'(rdata_valid), DW'(ev));
    if (ev) check({phase, " data"}, rdata, out_d);
  endtask

  task automatic idle_inputs();
    strobe_cpu_n = 1; strobe_ctl_n = 1; advance_n = 1;
    sel_pipe_n = 0; sel_hi = 1; sel_lo_n = 0;
    wr_all_n = 1; lane_gate_n = 1; lane_wr_n = '1;
    addr_in = '0; wdata = '0;
  endtask

  task automatic tick();
    @(negedge clk);
    compare();
    idle_inputs();
  endtask

  function automatic logic [DW-1:0] pattern(input int i);
    return (DW'(i) * 36'h1_2345) ^ 36'hA_5A5A_5A5A;
  endfunction

  task automatic ctl_read(input int a);
    strobe_ctl_n = 0; addr_in = AW'(a); tick();
  endtask

  task automatic cpu_read(input int a);
    strobe_cpu_n = 0; addr_in = AW'(a); tick();
  endtask

  task automatic ctl_write_all(input int a, input logic [DW-1:0] d);
    strobe_ctl_n = 0; wr_all_n = 0; addr_in = AW'(a); wdata = d; tick();
  endtask

  task automatic adv(input int n);
    for (int i = 0; i < n; i++) begin advance_n = 0; tick(); end
  endtask

  task automatic hold(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < WORDS; i++) ref_mem[i] = '0;
    idle_inputs();
    burst_linear = 1; out_en_n = 0; rst = 1;
    phase = "R1 reset";
    hold(3);
    rst = 0;
    check("R1 valid low after reset", DW'(rdata_valid), '0);

    phase = "R8 R12 global fill";
    for (int i = 0; i < WORDS; i++) begin
      lane_gate_n = 0; lane_wr_n = 4'b1110;
      ctl_write_all(i, pattern(i));
    end
    hold(2);

    phase = "R2 R5 linear bursts";
    burst_linear = 1;
    for (int s = 0; s < 4; s++) begin ctl_read(8'h10 + s); adv(3); end
    hold(2);

    phase = "R6 interleaved bursts";
    burst_linear = 0;
    for (int s = 0; s < 4; s++) begin cpu_read(8'h24 + s); adv(3); end
    hold(2);

    phase = "R4 hold and step";
    burst_linear = 1;
    ctl_read(8'h43); hold(2); adv(1); hold(1); adv(4);
    hold(2);

    phase = "R3 ignored processor strobe";
    cpu_read(8'h50); adv(1);
    strobe_cpu_n = 0; sel_pipe_n = 1; addr_in = 8'h99; tick();
    adv(1); hold(1);
    hold(2);

    phase = "R7 lane writes";
    strobe_ctl_n = 0; lane_gate_n = 0; lane_wr_n = 4'b1010;
    addr_in = 8'h60; wdata = 36'hF_FFFF_FFFF; tick();
    strobe_ctl_n = 0; lane_gate_n = 0; lane_wr_n = 4'b0111;
    addr_in = 8'h61; wdata = 36'h1_2345_6789; tick();
    strobe_ctl_n = 0; lane_gate_n = 1; lane_wr_n = 4'b0000;
    addr_in = 8'h62; wdata = 36'h0; tick();
    ctl_read(8'h60); adv(3);
    hold(2);

    phase = "R9 write ownership";
    ctl_write_all(8'h70, 36'h0_0000_1111);
    for (int i = 0; i < 3; i++) begin
      advance_n = 0; lane_gate_n = 0; lane_wr_n = '0; wdata = 36'h3_0000_0000 + 36'(i); tick();
    end
    strobe_cpu_n = 0; wr_all_n = 0; addr_in = 8'h72; wdata = 36'hD_EADB_EEF0; tick();
    adv(1);
    ctl_read(8'h70); adv(3);
    hold(2);

    phase = "R11 deselect";
    strobe_ctl_n = 0; sel_hi = 0; addr_in = 8'h10; tick(); adv(2);
    strobe_ctl_n = 0; sel_lo_n = 1; addr_in = 8'h10; wr_all_n = 0; wdata = '0; tick(); adv(2);
    strobe_ctl_n = 0; sel_pipe_n = 1; addr_in = 8'h11; tick(); adv(2);
    ctl_read(8'h20); adv(1);
    strobe_ctl_n = 0; sel_hi = 0; addr_in = 8'h30; tick(); hold(3);
    ctl_read(8'h11); hold(2);

    phase = "R10 output enable";
    ctl_read(8'h34); adv(1);
    #1 out_en_n = 1;
    #1 check("R10 valid drops without clock", DW'(rdata_valid), '0);
    out_en_n = 0;
    #1 check("R10 valid returns without clock", DW'(rdata_valid), DW'(1));
    check("R10 data while enabled", rdata, pattern(8'h34));
    adv(1); out_en_n = 1; adv(1); out_en_n = 0; hold(3);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule